// File: doc/BRIEF.md
# Time-Shared Three-Pair Wide Subtractor

This block takes six wide operands, computes three differences with a single subtractor, and reports the three results together. All logic runs on one fast clock. The subtractor's registers are written only on a free-running enable that is high on one fast cycle in four. Because of this, the arithmetic has four fast cycles to settle, and the width can exceed what one fast cycle could subtract. The enable also paces the sequencer.

A one-cycle new-data strobe captures all six operands. The same strobe loads a start request that is stretched over four fast cycles, so the enable is guaranteed to see it. The sequencer then steps through these states: IDLE, LOAD_AB, SUB_AB, LOAD_CD, SUB_CD, LOAD_EF, SUB_EF and DONE. Its transitions are:
- IDLE to LOAD_AB, on an enabled cycle while the request is visible.
- Each LOAD state to the SUB state of the same pair.
- SUB_AB to LOAD_CD, SUB_CD to LOAD_EF, and SUB_EF to DONE.
- DONE back to IDLE, which publishes the three results and pulses done.

Every transition happens only on an enabled cycle. The surrounding logic waits for done, then reads the results. While busy is high, the block ignores new strobes.

Top module: `triple_diff_unit`

## Requirements
- R1: When new_data is high on a rising edge and busy is low, all six operand buses are captured on that edge. Later changes on the operand buses do not affect the results.
- R2: An internal enable is high on every fourth fast cycle. After reset release it is high during the cycle that follows the 3rd, 7th, 11th and later non-reset edges. The sequencer and the subtractor registers change only on edges where the enable is high.
- R3: A capture loads a start request that stays visible for four fast cycles. The sequencer leaves IDLE at the first enabled edge after the capture edge, so every accepted strobe produces a sequence.
- R4: The pairs are processed in a fixed order: a-b, then c-d, then e-f. Each pair first loads the subtractor input registers and then captures the difference. Result buses ab, cd and ef carry the differences a-b, c-d and e-f.
- R5: Each result equals the minuend minus the subtrahend, modulo 2^W. Its borrow flag is 1 exactly when the minuend is less than the subtrahend as an unsigned number.
- R6: done is high for exactly one fast cycle. It goes high on the edge that is 28 fast edges after the first enabled edge following the capture edge, which is 29 to 32 edges after capture.
- R7: The result and borrow outputs change only on the edge that raises done, and they hold their values until the next done.
- R8: busy is high from the capture edge until the edge that raises done. A strobe that arrives while busy is high is ignored and does not change the captured operands.
- R9: A synchronous active-high reset clears the enable counter, the start request, the sequencer, done and the result outputs. During reset and after it, done, busy and all results read 0 until the first sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast clock |
| rst | input | 1 | synchronous active-high reset |
| new_data | input | 1 | one-cycle strobe that captures the operands |
| op_a | input | W | minuend of pair ab |
| op_b | input | W | subtrahend of pair ab |
| op_c | input | W | minuend of pair cd |
| op_d | input | W | subtrahend of pair cd |
| op_e | input | W | minuend of pair ef |
| op_f | input | W | subtrahend of pair ef |
| res_ab | output | W | a - b modulo 2^W |
| res_cd | output | W | c - d modulo 2^W |
| res_ef | output | W | e - f modulo 2^W |
| brw_ab | output | 1 | borrow of a - b |
| brw_cd | output | 1 | borrow of c - d |
| brw_ef | output | 1 | borrow of e - f |
| done | output | 1 | one-cycle pulse when results are published |
| busy | output | 1 | high while a request or a sequence is in progress |

## Verification
The assertions assume that reset is held over at least one edge before the first clock edge that matters. They also assume that new_data is a clean, edge-sampled level. Beyond that they place no restriction on when strobes arrive, because strobes that arrive during busy are part of the intended behaviour.

The stimulus drives all inputs on the falling edge. It launches jobs at varied phases relative to the enable. It also injects extra strobes into running sequences, including the cycle directly after a capture, when the sequencer is still in IDLE. Finally, it scrambles the operand buses after every capture.

// File: rtl/tdu_pkg.sv
package tdu_pkg;

    // length of the stretched start request in fast cycles
    localparam int REQ_LEN = 4;

    // number of operand pairs handled per sequence
    localparam int NUM_PAIRS = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_AB,
        ST_SUB_AB,
        ST_LOAD_CD,
        ST_SUB_CD,
        ST_LOAD_EF,
        ST_SUB_EF,
        ST_DONE
    } seq_state_t;

    typedef logic [1:0] pair_idx_t;

endpackage

// File: rtl/tdu_enable_gen.sv
module tdu_enable_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic en
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign en = (cnt_q == LAST);

endmodule

// File: rtl/tdu_req_stretch.sv
module tdu_req_stretch #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic req
);
    logic [LEN-1:0] sr_q;

    // loaded with all ones, then drained by one bit per fast cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= '1;
        end else begin
            sr_q <= {1'b0, sr_q[LEN-1:1]};
        end
    end

    assign req = sr_q[0];

endmodule

// File: rtl/tdu_operand_bank.sv
module tdu_operand_bank #(
    parameter int W = 64,
    parameter int N = 6
) (
    input  logic                clk,
    input  logic                capture,
    input  logic [N-1:0][W-1:0] ops_in,
    output logic [N-1:0][W-1:0] ops_q
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (capture) begin
                ops_q[i] <= ops_in[i];
            end
        end
    end

endmodule

// File: rtl/tdu_sequencer.sv
module tdu_sequencer
    import tdu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       req,
    output seq_state_t state,
    output pair_idx_t  sel,
    output logic       load_in,
    output logic       cap_diff,
    output logic       publish,
    output logic       seq_busy,
    output logic       done
);
    seq_state_t state_q;
    seq_state_t state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: every move waits for the enable
    always_comb begin
        state_d = state_q;
        if (en) begin
            unique case (state_q)
                ST_IDLE:    if (req) state_d = ST_LOAD_AB;
                ST_LOAD_AB: state_d = ST_SUB_AB;
                ST_SUB_AB:  state_d = ST_LOAD_CD;
                ST_LOAD_CD: state_d = ST_SUB_CD;
                ST_SUB_CD:  state_d = ST_LOAD_EF;
                ST_LOAD_EF: state_d = ST_SUB_EF;
                ST_SUB_EF:  state_d = ST_DONE;
                ST_DONE:    state_d = ST_IDLE;
            endcase
        end
    end

    // outputs decoded from the current state
    always_comb begin
        sel      = 2'd0;
        load_in  = 1'b0;
        cap_diff = 1'b0;
        publish  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD_AB: begin sel = 2'd0; load_in  = en; end
            ST_SUB_AB:  begin sel = 2'd0; cap_diff = en; end
            ST_LOAD_CD: begin sel = 2'd1; load_in  = en; end
            ST_SUB_CD:  begin sel = 2'd1; cap_diff = en; end
            ST_LOAD_EF: begin sel = 2'd2; load_in  = en; end
            ST_SUB_EF:  begin sel = 2'd2; cap_diff = en; end
            ST_DONE:    publish = en;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
        end else begin
            done <= publish;
        end
    end

    assign state    = state_q;
    assign seq_busy = (state_q != ST_IDLE);

endmodule

// File: rtl/tdu_sub_core.sv
module tdu_sub_core
    import tdu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [2*NUM_PAIRS-1:0][W-1:0]     ops,
    input  pair_idx_t                         sel,
    input  logic                              load_in,
    input  logic                              cap_diff,
    input  logic                              publish,
    output logic [NUM_PAIRS-1:0][W:0]         res
);
    logic [W-1:0] in0_q;
    logic [W-1:0] in1_q;
    logic [W:0]   diff_w;
    logic [2:0]   idx_min;
    logic [2:0]   idx_sub;

    assign idx_min = {sel, 1'b0};
    assign idx_sub = {sel, 1'b1};

    // subtractor input registers, written on a LOAD step
    always_ff @(posedge clk) begin
        if (rst) begin
            in0_q <= '0;
            in1_q <= '0;
        end else if (load_in) begin
            in0_q <= ops[idx_min];
            in1_q <= ops[idx_sub];
        end
    end

    // wide path: has a full enable period to settle
    assign diff_w = {1'b0, in0_q} - {1'b0, in1_q};

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        logic [W:0] slot_q;
        logic [W:0] out_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (cap_diff && (sel == pair_idx_t'(i))) begin
                slot_q <= diff_w;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                out_q <= '0;
            end else if (publish) begin
                out_q <= slot_q;
            end
        end

        assign res[i] = out_q;
    end

endmodule

// File: rtl/triple_diff_unit.sv
module triple_diff_unit
    import tdu_pkg::*;
#(
    parameter int W   = 64,
    parameter int DIV = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         new_data,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] op_c,
    input  logic [W-1:0] op_d,
    input  logic [W-1:0] op_e,
    input  logic [W-1:0] op_f,
    output logic [W-1:0] res_ab,
    output logic [W-1:0] res_cd,
    output logic [W-1:0] res_ef,
    output logic         brw_ab,
    output logic         brw_cd,
    output logic         brw_ef,
    output logic         done,
    output logic         busy
);
    localparam int NOPS = 2 * NUM_PAIRS;

    logic                      en_w;
    logic                      req_w;
    logic                      capture_w;
    logic                      seq_busy_w;
    logic                      load_in_w;
    logic                      cap_diff_w;
    logic                      publish_w;
    pair_idx_t                 sel_w;
    seq_state_t                state_w;
    logic [NOPS-1:0][W-1:0]    ops_in_w;
    logic [NOPS-1:0][W-1:0]    ops_q_w;
    logic [NUM_PAIRS-1:0][W:0] res_w;

    assign busy      = seq_busy_w | req_w;
    assign capture_w = new_data & ~busy;
    assign ops_in_w  = {op_f, op_e, op_d, op_c, op_b, op_a};

    tdu_enable_gen #(.DIV(DIV)) u_en (
        .clk (clk),
        .rst (rst),
        .en  (en_w)
    );

    tdu_req_stretch #(.LEN(REQ_LEN)) u_req (
        .clk  (clk),
        .rst  (rst),
        .load (capture_w),
        .req  (req_w)
    );

    tdu_operand_bank #(.W(W), .N(NOPS)) u_bank (
        .clk     (clk),
        .capture (capture_w),
        .ops_in  (ops_in_w),
        .ops_q   (ops_q_w)
    );

    tdu_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .en       (en_w),
        .req      (req_w),
        .state    (state_w),
        .sel      (sel_w),
        .load_in  (load_in_w),
        .cap_diff (cap_diff_w),
        .publish  (publish_w),
        .seq_busy (seq_busy_w),
        .done     (done)
    );

    tdu_sub_core #(.W(W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .ops      (ops_q_w),
        .sel      (sel_w),
        .load_in  (load_in_w),
        .cap_diff (cap_diff_w),
        .publish  (publish_w),
        .res      (res_w)
    );

    assign res_ab = res_w[0][W-1:0];
    assign brw_ab = res_w[0][W];
    assign res_cd = res_w[1][W-1:0];
    assign brw_cd = res_w[1][W];
    assign res_ef = res_w[2][W-1:0];
    assign brw_ef = res_w[2][W];

endmodule

// File: rtl/tdu_checker.sv
module tdu_checker
    import tdu_pkg::*;
#(
    parameter int W   = 64,
    parameter int DIV = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          en,
    input  logic                          req,
    input  seq_state_t                    state,
    input  logic                          busy,
    input  logic                          new_data,
    input  logic                          done,
    input  logic [NUM_PAIRS-1:0][W:0]     res,
    input  logic [2*NUM_PAIRS-1:0][W-1:0] ops
);
    logic [7:0] gap_q;
    logic       seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (en) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != 8'hFF) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    p_en_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (en && seen_q) |-> (gap_q == 8'(DIV - 1)));

    p_state_on_en_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(state));

    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |=> req ##1 req ##1 req);

    p_leave_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && en && req) |=> (state == ST_LOAD_AB));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_res_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(res) |-> done);

    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (new_data && busy) |=> $stable(ops));

    p_busy_cover_r8: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |-> busy);

endmodule

bind triple_diff_unit tdu_checker #(.W(W), .DIV(DIV)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en_w),
    .req      (req_w),
    .state    (state_w),
    .busy     (busy),
    .new_data (new_data),
    .done     (done),
    .res      (res_w),
    .ops      (ops_q_w)
);

// File: tb/test_triple_diff_unit.sv
`timescale 1ns/1ps
module test_triple_diff_unit;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         new_data = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0, op_c = '0, op_d = '0, op_e = '0, op_f = '0;
    logic [W-1:0] res_ab, res_cd, res_ef;
    logic         brw_ab, brw_cd, brw_ef, done, busy;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    triple_diff_unit #(.W(W), .DIV(4)) i_triple_diff_unit (
        .clk(clk), .rst(rst), .new_data(new_data),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d), .op_e(op_e), .op_f(op_f),
        .res_ab(res_ab), .res_cd(res_cd), .res_ef(res_ef),
        .brw_ab(brw_ab), .brw_cd(brw_cd), .brw_ef(brw_ef),
        .done(done), .busy(busy)
    );

    always #2.5 clk = ~clk;

    // reference model, behavioural
    int         k = 0;
    int         acc_k = 0;
    int         done_k = 0;
    int         lat = 0;
    int         jobs_acc = 0;
    int         jobs_done = 0;
    bit         m_busy = 0;
    bit         m_done = 0;
    logic [W:0] m_res  [3];
    logic [W:0] m_pend [3];

    function automatic logic [W:0] ref_diff(input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W:0] d;
        d[W-1:0] = x - y;
        d[W]     = (x < y);
        return d;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            k = 0; m_busy = 0; m_done = 0;
            for (int i = 0; i < 3; i++) m_res[i] = '0;
        end else begin
            k++;
            m_done = 0;
            if (m_busy && k == done_k) begin
                m_done = 1; m_busy = 0; lat = k - acc_k; jobs_done++;
                for (int i = 0; i < 3; i++) m_res[i] = m_pend[i];
            end else if (!m_busy && new_data) begin
                m_pend[0] = ref_diff(op_a, op_b);
                m_pend[1] = ref_diff(op_c, op_d);
                m_pend[2] = ref_diff(op_e, op_f);
                acc_k  = k;
                done_k = k + (4 - (k % 4)) + 28;
                m_busy = 1;
                jobs_acc++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [W:0] act, input logic [W:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at t=%0t", tag, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(done === m_done, "R2/R6 done", {{W{1'b0}}, done}, {{W{1'b0}}, m_done});
            check(busy === m_busy, "R8 busy", {{W{1'b0}}, busy}, {{W{1'b0}}, m_busy});
            check({brw_ab, res_ab} === m_res[0], "R4/R5/R7 ab", {brw_ab, res_ab}, m_res[0]);
            check({brw_cd, res_cd} === m_res[1], "R4/R5/R7 cd", {brw_cd, res_cd}, m_res[1]);
            check({brw_ef, res_ef} === m_res[2], "R4/R5/R7 ef", {brw_ef, res_ef}, m_res[2]);
            if (m_done)
                check(lat >= 29 && lat <= 32, "R3 latency", (W+1)'(lat), (W+1)'(29));
        end
    end

    function automatic logic [W-1:0] rnd();
        return {$urandom, $urandom};
    endfunction

    task automatic run_job(input logic [W-1:0] a, b, c, d, e, f,
                           input int pre_gap, input int intrude_at);
        repeat (pre_gap) @(negedge clk);
        while (m_busy) @(negedge clk);
        op_a = a; op_b = b; op_c = c; op_d = d; op_e = e; op_f = f;
        new_data = 1'b1;
        @(negedge clk);
        new_data = 1'b0;
        // R1: later bus changes must not leak into results
        op_a = rnd(); op_b = rnd(); op_c = rnd(); op_d = rnd(); op_e = rnd(); op_f = rnd();
        if (intrude_at >= 0) begin
            repeat (intrude_at) @(negedge clk);
            op_a = rnd(); op_b = rnd(); op_c = rnd();
            new_data = 1'b1;             // R8: must be ignored
            @(negedge clk);
            new_data = 1'b0;
        end
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin m_res[i] = '0; m_pend[i] = '0; end
        repeat (3) @(negedge clk);
        // R9: reset state
        check(done === 1'b0 && busy === 1'b0, "R9 reset flags", {{(W-1){1'b0}}, done, busy}, '0);
        check({res_ab, res_cd, res_ef} === '0, "R9 reset results", {1'b0, res_ab | res_cd | res_ef}, '0);
        rst = 1'b0;
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R9 after release", {{(W-1){1'b0}}, done, busy}, '0);

        // boundary operands: equal, wrap with borrow, max minus zero
        run_job(64'h1234, 64'h1234, 64'd0, 64'd1, '1, 64'd0, 0, -1);
        run_job(64'd0, '1, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'd5, 64'd7, 1, 0);
        // random jobs at every enable phase, some with intrusions
        for (int j = 0; j < 24; j++) begin
            run_job(rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), j % 5,
                    (j % 3 == 0) ? -1 : int'($urandom_range(0, 26)));
        end
        // back-to-back: strobe held high across done
        new_data = 1'b1;
        op_a = rnd(); op_b = rnd(); op_c = rnd(); op_d = rnd(); op_e = rnd(); op_f = rnd();
        repeat (40) @(negedge clk);
        new_data = 1'b0;
        while (m_busy) @(negedge clk);
        repeat (4) @(negedge clk);

        check(jobs_done == jobs_acc && jobs_done >= 27, "R1/R3 completed jobs",
              (W+1)'(jobs_done), (W+1)'(jobs_acc));
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog R6 actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule